// File: doc/BRIEF.md
# Sum-of-Products Logic Array with Fixed OR Grouping

This block is a small configurable logic array. Twelve input variables feed sixteen product terms. Each product term is an AND gate whose inputs are chosen by configuration links. Six outputs each OR together a fixed, hard-wired group of product terms. Only the AND side can be configured. The OR side is uneven: the two lowest outputs each collect four terms, and the other four outputs each collect two.

The configuration is 384 link bits: two links per input per term. They are shifted in one bit per accepted cycle on a serial port. When the last bit has been taken, the block raises a completion flag. From then on the six outputs follow the inputs combinationally. Until then they are held low. Any further configuration strobes are ignored until a synchronous reset, which clears every link and the flag.

Top module: `sop_array`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears every link, the bit counter and `cfg_done`. While `cfg_done` is low, `out_f` is 0.
- R2: A bit is accepted on a rising edge when `cfg_valid` is high and `cfg_done` is low. Accepted bit number k (counted from 0) is stored as the link for term k/24, input (k mod 24)/2, and polarity k mod 2, where polarity 0 is the true link and 1 is the complement link. `cfg_done` goes high on the edge that accepts bit 383, and not before.
- R3: While `cfg_done` is low, `out_f` is 0 for every input value.
- R4: Each input of a term is described by its link pair (true, complement). Pair 10 requires the input to be 1. Pair 01 requires it to be 0. Pair 00 leaves the input out of the term. The term is 1 only when every requirement holds.
- R5: A term with all 24 links clear evaluates to 0.
- R6: A term that has both links of any input set evaluates to 0 for all input values.
- R7: The OR grouping is fixed as follows. `out_f[0]` is terms 0–3, `out_f[1]` is terms 4–7, `out_f[2]` is terms 8–9, `out_f[3]` is terms 10–11, `out_f[4]` is terms 12–13, and `out_f[5]` is terms 14–15.
- R8: Once `cfg_done` is high, it stays high. Further `cfg_valid` strobes change neither the stored links nor the outputs until reset.
- R9: With `cfg_done` high, `out_f` follows `in_vars` without waiting for a clock edge.
- R10: Cycles with `cfg_valid` low do not advance the load, so a load that contains gaps gives the same configuration as one without gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration logic |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Configuration bit strobe |
| cfg_bit | input | 1 | Serial configuration link value |
| cfg_done | output | 1 | All 384 links have been loaded |
| in_vars | input | 12 | Input variables |
| out_f | output | 6 | Sum-of-products outputs |

## Verification
Random link maps are loaded. Most input positions in them are don't-care, and the rest are a mix of true and complement literals, so that terms match often enough. Random input vectors then show whether literal polarity and the OR grouping are correct. A map of blank terms tells apart the "unused term reads 0" rule from a plain AND of no inputs. A map in which every term holds one conflicting pair exposes any decoding that lets a double-link input pass. A map with a single true literal per term, driven with walking-one inputs, pins each term to its output group and catches any slip in the serial bit order. Loads with idle gaps, and strobes sent after completion, show that only accepted bits move the load, and that a finished configuration is frozen.

// File: rtl/sop_pkg.sv
package sop_pkg;
  // First product term of output o under the fixed, uneven OR grouping.
  function automatic int first_term(input int o, input int n_wide,
                                    input int wide_terms, input int narrow_terms);
    if (o < n_wide) return o * wide_terms;
    return n_wide * wide_terms + (o - n_wide) * narrow_terms;
  endfunction

  // Number of product terms ORed into output o.
  function automatic int group_size(input int o, input int n_wide,
                                    input int wide_terms, input int narrow_terms);
    return (o < n_wide) ? wide_terms : narrow_terms;
  endfunction
endpackage

// File: rtl/sop_cfg_loader.sv
module sop_cfg_loader #(
  parameter int CFG_BITS = 384,
  localparam int CNT_W = $clog2(CFG_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_valid,
  input  logic                cfg_bit,
  output logic [CFG_BITS-1:0] links,
  output logic                done,
  output logic [CNT_W-1:0]    count,
  output logic                accept
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CFG_BITS - 1);

  assign accept = cfg_valid && !done;

  always_ff @(posedge clk) begin
    if (rst) begin
      links <= '0;
      count <= '0;
      done  <= 1'b0;
    end else if (accept) begin
      links[count] <= cfg_bit;
      count        <= count + CNT_W'(1);
      if (count == LAST) done <= 1'b1;
    end
  end
endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane #(
  parameter int N_IN   = 12,
  parameter int N_TERM = 16,
  localparam int ROW_W = 2 * N_IN,
  localparam int CFG_BITS = ROW_W * N_TERM
) (
  input  logic [CFG_BITS-1:0] links,
  input  logic [N_IN-1:0]     x,
  output logic [N_TERM-1:0]   hit
);
  // One product term: the pair (true, complement) of input i sits at 2i, 2i+1.
  // A blank row is treated as unused and reads 0.
  function automatic logic term_value(input logic [ROW_W-1:0] row,
                                      input logic [N_IN-1:0] xv);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < N_IN; i++) begin
      if (row[2*i]   && !xv[i]) ok = 1'b0;
      if (row[2*i+1] &&  xv[i]) ok = 1'b0;
    end
    return ok && (|row);
  endfunction

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [ROW_W-1:0] row;
    assign row    = links[t*ROW_W +: ROW_W];
    assign hit[t] = term_value(row, x);
  end
endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane #(
  parameter int N_WIDE       = 2,
  parameter int WIDE_TERMS   = 4,
  parameter int N_NARROW     = 4,
  parameter int NARROW_TERMS = 2,
  localparam int N_OUT  = N_WIDE + N_NARROW,
  localparam int N_TERM = N_WIDE * WIDE_TERMS + N_NARROW * NARROW_TERMS
) (
  input  logic [N_TERM-1:0] hit,
  output logic [N_OUT-1:0]  f
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    localparam int FIRST = sop_pkg::first_term(o, N_WIDE, WIDE_TERMS, NARROW_TERMS);
    localparam int CNT   = sop_pkg::group_size(o, N_WIDE, WIDE_TERMS, NARROW_TERMS);
    assign f[o] = |hit[FIRST +: CNT];
  end
endmodule

// File: rtl/sop_array.sv
module sop_array #(
  parameter int N_IN         = 12,
  parameter int N_WIDE       = 2,
  parameter int WIDE_TERMS   = 4,
  parameter int N_NARROW     = 4,
  parameter int NARROW_TERMS = 2,
  localparam int N_OUT    = N_WIDE + N_NARROW,
  localparam int N_TERM   = N_WIDE * WIDE_TERMS + N_NARROW * NARROW_TERMS,
  localparam int CFG_BITS = 2 * N_IN * N_TERM
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_valid,
  input  logic             cfg_bit,
  output logic             cfg_done,
  input  logic [N_IN-1:0]  in_vars,
  output logic [N_OUT-1:0] out_f
);
  localparam int CNT_W = $clog2(CFG_BITS + 1);

  // Named internal events, visible to the bound checker.
  logic [CFG_BITS-1:0] links;
  logic [CNT_W-1:0]    load_count;
  logic                load_accept;
  logic [N_TERM-1:0]   term_hit;
  logic [N_OUT-1:0]    or_out;

  sop_cfg_loader #(.CFG_BITS(CFG_BITS)) u_loader (
    .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_bit(cfg_bit),
    .links(links), .done(cfg_done), .count(load_count), .accept(load_accept)
  );

  sop_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
    .links(links), .x(in_vars), .hit(term_hit)
  );

  sop_or_plane #(
    .N_WIDE(N_WIDE), .WIDE_TERMS(WIDE_TERMS),
    .N_NARROW(N_NARROW), .NARROW_TERMS(NARROW_TERMS)
  ) u_or (
    .hit(term_hit), .f(or_out)
  );

  assign out_f = cfg_done ? or_out : '0;
endmodule

// File: rtl/sop_array_chk.sv
module sop_array_chk #(
  parameter int CFG_BITS = 384,
  parameter int N_TERM   = 16,
  parameter int N_OUT    = 6,
  parameter int CNT_W    = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_done,
  input logic [N_OUT-1:0] out_f,
  input logic             load_accept,
  input logic [N_TERM-1:0] term_hit,
  input logic [CNT_W-1:0] load_count
);
  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!cfg_done && load_count == '0));

  // R3
  idle_outputs_low_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_done |-> (out_f == '0));

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_done |=> cfg_done);

  // R2
  done_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_done) |-> $past(load_accept));

  // R2
  full_count_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_done |-> (load_count == CNT_W'(CFG_BITS)));

  // R10
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load_accept |=> $stable(load_count));

  // R7
  out_needs_term_chk: assert property (@(posedge clk) disable iff (rst)
    (out_f != '0) |-> (term_hit != '0));
endmodule

bind sop_array sop_array_chk #(
  .CFG_BITS(CFG_BITS), .N_TERM(N_TERM), .N_OUT(N_OUT), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .cfg_done(cfg_done), .out_f(out_f),
  .load_accept(load_accept), .term_hit(term_hit), .load_count(load_count)
);

// File: tb/test_sop_array.sv
module test_sop_array;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 12;
  localparam int NT = 16;
  localparam int NB = 2 * NI * NT;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_valid = 1'b0;
  logic          cfg_bit = 1'b0;
  logic          cfg_done;
  logic [NI-1:0] in_vars = '0;
  logic [5:0]    out_f;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit ended  = 0;
  logic [NB-1:0] map;

  sop_array i_sop_array (
    .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_bit(cfg_bit),
    .cfg_done(cfg_done), .in_vars(in_vars), .out_f(out_f)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !ended) begin
      ended = 1;
      fails++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // Which output owns term t.
  function automatic int owner(input int t);
    return (t < 8) ? t / 4 : 2 + (t - 8) / 2;
  endfunction

  // Reference evaluation: decode each link pair as a literal.
  function automatic logic [5:0] model(input logic [NB-1:0] m, input logic [NI-1:0] x);
    logic [5:0] r;
    r = '0;
    for (int t = 0; t < NT; t++) begin
      bit alive = 1;
      bit any   = 0;
      for (int i = 0; i < NI; i++) begin
        logic [1:0] pr;
        pr = {m[t*24 + 2*i], m[t*24 + 2*i + 1]};
        case (pr)
          2'b10: begin any = 1; if (!x[i]) alive = 0; end
          2'b01: begin any = 1; if (x[i])  alive = 0; end
          2'b11: begin any = 1; alive = 0; end
          default: ;
        endcase
      end
      if (alive && any) r[owner(t)] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [NB-1:0] random_map();
    logic [NB-1:0] m;
    m = '0;
    for (int t = 0; t < NT; t++)
      for (int i = 0; i < NI; i++) begin
        int r = $urandom % 100;
        if (r < 15)      m[t*24 + 2*i]     = 1'b1;
        else if (r < 30) m[t*24 + 2*i + 1] = 1'b1;
      end
    return m;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cfg_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Serial load, term 0 / input 0 / true link first; optional idle gaps.
  task automatic load(input logic [NB-1:0] m, input bit gaps);
    for (int k = 0; k < NB; k++) begin
      if (gaps && ($urandom % 4 == 0)) begin
        @(negedge clk);
        cfg_valid = 1'b0;
        cfg_bit   = ~m[k];
      end
      @(negedge clk);
      if (k == NB - 1) begin
        in_vars = NI'($urandom);
        #1;
        chk("R2 done before last bit", 32'(cfg_done), 32'd0);
        chk("R3 outputs low while loading", 32'(out_f), 32'd0);
      end
      cfg_valid = 1'b1;
      cfg_bit   = m[k];
    end
    @(negedge clk);
    cfg_valid = 1'b0;
    chk("R2 done after 384 bits", 32'(cfg_done), 32'd1);
  endtask

  task automatic rand_checks(input string req, input int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      in_vars = NI'($urandom);
      #1;
      chk(req, 32'(out_f), 32'(model(map, in_vars)));
    end
  endtask

  initial begin
    void'($urandom(32'd4242));

    // R1: reset state
    do_reset();
    in_vars = 12'hFFF;
    #1;
    chk("R1 done after reset", 32'(cfg_done), 32'd0);
    chk("R1 outputs after reset", 32'(out_f), 32'd0);

    // R4 R7 R10: random map loaded with gaps
    map = random_map();
    load(map, 1'b1);
    rand_checks("R4 R7 R10 random map", 300);

    // R9: input change with no clock edge in between
    @(negedge clk);
    in_vars = 12'h000;
    #1;
    chk("R9 comb a", 32'(out_f), 32'(model(map, 12'h000)));
    in_vars = 12'hFFF;
    #1;
    chk("R9 comb b", 32'(out_f), 32'(model(map, 12'hFFF)));

    // R8: strobes after completion are ignored
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      cfg_valid = 1'b1;
      cfg_bit   = ~map[k % NB];
    end
    @(negedge clk);
    cfg_valid = 1'b0;
    chk("R8 done stays high", 32'(cfg_done), 32'd1);
    rand_checks("R8 config frozen", 60);

    // R1 R5: reset clears, blank terms read 0
    do_reset();
    #1;
    chk("R1 done cleared by reset", 32'(cfg_done), 32'd0);
    map = '0;
    load(map, 1'b0);
    rand_checks("R5 blank terms", 40);
    for (int i = 0; i < NI; i++) begin
      @(negedge clk);
      in_vars = NI'(1) << i;
      #1;
      chk("R5 blank walking one", 32'(out_f), 32'd0);
    end

    // R6: a conflicting pair kills the term
    do_reset();
    map = random_map();
    for (int t = 0; t < NT; t++) begin
      map[t*24 + 2*(t % NI)]     = 1'b1;
      map[t*24 + 2*(t % NI) + 1] = 1'b1;
    end
    load(map, 1'b1);
    rand_checks("R6 conflict terms", 60);
    @(negedge clk);
    in_vars = 12'hFFF;
    #1;
    chk("R6 conflict all ones", 32'(out_f), 32'd0);

    // R7 R4: one true literal per term, on input t mod 12
    do_reset();
    map = '0;
    for (int t = 0; t < NT; t++) map[t*24 + 2*(t % NI)] = 1'b1;
    load(map, 1'b0);
    for (int i = 0; i < NI; i++) begin
      @(negedge clk);
      in_vars = NI'(1) << i;
      #1;
      chk("R7 group walking one", 32'(out_f), 32'(model(map, in_vars)));
    end
    @(negedge clk);
    in_vars = 12'h001;
    #1;
    chk("R7 input0 hits terms 0 and 12", 32'(out_f), 32'b010001);
    rand_checks("R7 single literal map", 40);

    // R4: single complement literal per term
    do_reset();
    map = '0;
    for (int t = 0; t < NT; t++) map[t*24 + 2*(t % NI) + 1] = 1'b1;
    load(map, 1'b0);
    @(negedge clk);
    in_vars = 12'hFFE;
    #1;
    chk("R4 complement literal", 32'(out_f), 32'b010001);
    rand_checks("R4 complement map", 40);

    // R4 R7: second random map, no gaps
    do_reset();
    map = random_map();
    load(map, 1'b0);
    rand_checks("R4 R7 random map two", 200);

    ended = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule